// File: doc/BRIEF.md
# Programmable PWM Time-Base with Action Qualifier

This block is a single-channel pulse-width modulator. A two-stage clock divider produces a count tick. An up-counting time base advances on each tick and wraps at a programmable period. Four counter events can each drive a programmable action on two outputs: counter at zero, counter at period, counter at compare A while counting up, and counter at compare B while counting up. The compare values can be double-buffered so that a new value only takes effect at the start of a period.

An event trigger stage selects one event for an ADC start-of-conversion strobe and one event for an interrupt. The interrupt can be set to fire only on every Nth selected event. A latched interrupt flag stays high until software clears it.

A shared sync enable input holds every instance's counter and divider while it is low. Several instances can therefore be started on the same clock edge and keep aligned edges. Configuration is written through a simple address and data write port. Compare writes, period writes, action settings and mode changes all take effect on the clock edge that accepts the write.

Top module: `pwm_action_timer`

## Requirements
- R1: While `syncEn` is low, the counter holds its value, the divider restarts from zero, and no event, SOC pulse or interrupt pulse occurs. The first tick comes exactly D clocks after `syncEn` rises, where D is the divide ratio.
- R2: In up-count mode the counter steps by one on each tick from 0 to the period value (address 1). On the tick after it reaches or exceeds the period, it returns to 0. `cntVal` always shows the counter.
- R3: The tick divide ratio is the product of two factors, both set in address 0. The coarse code in bits [7:5] contributes 2^code. The fast code in bits [4:2] contributes 1 for code 0 and 2*code otherwise. So coarse 1 with fast 4 divides by 16.
- R4: Mode field bits [1:0] of address 0: code 3 freezes the counter, and in that state no counter events are produced. Codes 0 to 2 count up.
- R5: Address 5 (output A) and address 6 (output B) each hold one 2-bit action per event. The fields are zero in [1:0], period in [3:2], compare-A-up in [5:4] and compare-B-up in [7:6]. The action codes are 0 none, 1 clear, 2 set and 3 toggle. An output changes on the clock edge of the tick at which its event occurs.
- R6: When several events occur on the same tick, only the highest-priority event whose action is not "none" is applied. The priority order is compare A, then compare B, then period, then zero.
- R7: Address 4 enables shadowing: bit 0 for compare A and bit 1 for compare B. With shadowing on, writes to address 2 or 3 go to a shadow copy, which moves to the active compare on the zero event. With shadowing off, writes take effect at once.
- R8: Address 7 bit 5 enables the SOC strobe, and bits [7:6] select its event (0 zero, 1 period, 2 compare A, 3 compare B). `socPulse` is high for one clock on each selected event while the strobe is enabled.
- R9: Address 7 bit 0 enables the interrupt, bits [2:1] select its event (same encoding as R8), and bits [4:3] give N. Code 0 means never. The interrupt fires on every Nth selected event: `intPulse` goes high for one clock and `intFlag` is set. While `intFlag` is high, events are not counted and no further pulse occurs.
- R10: Writing address 8 with bit 0 set clears `intFlag` and restarts the event count. Disabling the interrupt also restarts the count.
- R11: After reset all configuration is zero. The counter, both outputs, the flag and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| syncEn | input | 1 | Shared start gate for counter and divider |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address |
| wrData | input | 16 | Register write data |
| pwmA | output | 1 | PWM output A |
| pwmB | output | 1 | PWM output B |
| intPulse | output | 1 | One-clock interrupt pulse |
| intFlag | output | 1 | Latched interrupt flag |
| socPulse | output | 1 | One-clock ADC start-of-conversion strobe |
| cntVal | output | 16 | Time-base counter value |

## Verification
A wrong divider or counter state shows up on `cntVal` at the next tick. It also skews every later edge on `pwmA`, `pwmB` and `socPulse`. A stale active compare value, left behind by a missed shadow load, moves the compare-driven edge in the very first period after the zero event. A wrong interrupt event count stays hidden until the Nth event, and then `intPulse` appears one event early or late. For these reasons the bench runs a behavioural model alongside the design and compares every output on every clock. The bench also forces coincident events, freeze mode and mid-count clears, so that a fault cannot wait out a short check window.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int CNT_W = 16;
  localparam int ADDR_W = 4;
  localparam int CS_W = 3;
  localparam int HS_W = 3;
  localparam int PRE_W = HS_W + 1 + (2 ** CS_W) - 1;
  localparam int NUM_CH = 2;

  localparam logic [ADDR_W-1:0] ADDR_TCFG   = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPA   = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMPB   = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_CMODE  = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_ACTA   = 4'd5;
  localparam logic [ADDR_W-1:0] ADDR_ACTB   = 4'd6;
  localparam logic [ADDR_W-1:0] ADDR_EVCFG  = 4'd7;
  localparam logic [ADDR_W-1:0] ADDR_INTCLR = 4'd8;

  localparam logic [1:0] MODE_FREEZE = 2'd3;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_CLEAR  = 2'd1,
    ACT_SET    = 2'd2,
    ACT_TOGGLE = 2'd3
  } pwmAct_e;

  typedef struct packed {
    logic zero;
    logic prd;
    logic cmpA;
    logic cmpB;
  } cntEvt_t;

  typedef struct packed {
    logic                     tick;
    logic                     freeze;
    logic [CNT_W-1:0]         period;
    logic                     cmpWrA;
    logic                     cmpWrB;
    logic [CNT_W-1:0]         cmpData;
    logic                     shadowA;
    logic                     shadowB;
    logic [NUM_CH-1:0][7:0]   actCfg;
  } dpCtrl_t;

  function automatic logic pickEvt(cntEvt_t e, logic [1:0] src);
    case (src)
      2'd0:    pickEvt = e.zero;
      2'd1:    pickEvt = e.prd;
      2'd2:    pickEvt = e.cmpA;
      default: pickEvt = e.cmpB;
    endcase
  endfunction

endpackage

// File: rtl/pwm_action_out.sv
module pwm_action_out
  import pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] actCfg,
  input  cntEvt_t    evt,
  output logic       pwmQ
);

  pwmAct_e winAct;

  // Priority: compare A, compare B, period, zero; "none" actions fall through.
  always_comb begin
    winAct = ACT_NONE;
    if (evt.cmpA && actCfg[5:4] != 2'd0)      winAct = pwmAct_e'(actCfg[5:4]);
    else if (evt.cmpB && actCfg[7:6] != 2'd0) winAct = pwmAct_e'(actCfg[7:6]);
    else if (evt.prd && actCfg[3:2] != 2'd0)  winAct = pwmAct_e'(actCfg[3:2]);
    else if (evt.zero && actCfg[1:0] != 2'd0) winAct = pwmAct_e'(actCfg[1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwmQ <= 1'b0;
    end else begin
      case (winAct)
        ACT_CLEAR:  pwmQ <= 1'b0;
        ACT_SET:    pwmQ <= 1'b1;
        ACT_TOGGLE: pwmQ <= ~pwmQ;
        default:    pwmQ <= pwmQ;
      endcase
    end
  end

  // R5
  no_evt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(evt.zero || evt.prd || evt.cmpA || evt.cmpB) |=> $stable(pwmQ));

endmodule

// File: rtl/pwm_count_path.sv
module pwm_count_path
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           ctl,
  output logic [CNT_W-1:0]  cnt,
  output cntEvt_t           evt,
  output logic [NUM_CH-1:0] pwmOut
);

  logic             run;
  logic [CNT_W-1:0] cmpActA;
  logic [CNT_W-1:0] cmpActB;
  logic [CNT_W-1:0] cmpShA;
  logic [CNT_W-1:0] cmpShB;

  assign run = ctl.tick && !ctl.freeze;

  always_comb begin
    evt.zero = run && (cnt == '0);
    evt.prd  = run && (cnt == ctl.period);
    evt.cmpA = run && (cnt == cmpActA);
    evt.cmpB = run && (cnt == cmpActB);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (run) begin
      if (cnt >= ctl.period) cnt <= '0;
      else                   cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmpActA <= '0;
      cmpActB <= '0;
      cmpShA  <= '0;
      cmpShB  <= '0;
    end else begin
      if (ctl.cmpWrA) begin
        if (ctl.shadowA) cmpShA  <= ctl.cmpData;
        else             cmpActA <= ctl.cmpData;
      end
      if (ctl.cmpWrB) begin
        if (ctl.shadowB) cmpShB  <= ctl.cmpData;
        else             cmpActB <= ctl.cmpData;
      end
      if (evt.zero && ctl.shadowA) cmpActA <= cmpShA;
      if (evt.zero && ctl.shadowB) cmpActB <= cmpShB;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pwm_action_out u_act (
      .clk    (clk),
      .rst    (rst),
      .actCfg (ctl.actCfg[ch]),
      .evt    (evt),
      .pwmQ   (pwmOut[ch])
    );
  end

  // R3
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.tick |=> $stable(cnt));

  // R4
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.freeze |=> $stable(cnt));

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.tick && !ctl.freeze && cnt >= ctl.period) |=> (cnt == '0));

endmodule

// File: rtl/pwm_regs_ctrl.sv
module pwm_regs_ctrl
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              syncEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  cntEvt_t           evt,
  output dpCtrl_t           ctl,
  output logic              intPulse,
  output logic              intFlag,
  output logic              socPulse
);

  logic [1:0]             modeSel;
  logic [HS_W-1:0]        fastCode;
  logic [CS_W-1:0]        coarseCode;
  logic [CNT_W-1:0]       periodReg;
  logic                   shA;
  logic                   shB;
  logic [NUM_CH-1:0][7:0] actReg;
  logic                   intEn;
  logic [1:0]             intSrc;
  logic [1:0]             intEvery;
  logic                   socEn;
  logic [1:0]             socSrc;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] fastFac;
  logic [PRE_W-1:0] divVal;
  logic             tick;
  logic [1:0]       evtCnt;
  logic             intClr;
  logic             intHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeSel    <= '0;
      fastCode   <= '0;
      coarseCode <= '0;
      periodReg  <= '0;
      shA        <= 1'b0;
      shB        <= 1'b0;
      actReg     <= '0;
      intEn      <= 1'b0;
      intSrc     <= '0;
      intEvery   <= '0;
      socEn      <= 1'b0;
      socSrc     <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_TCFG: begin
          modeSel    <= wrData[1:0];
          fastCode   <= wrData[4:2];
          coarseCode <= wrData[7:5];
        end
        ADDR_PERIOD: periodReg <= wrData;
        ADDR_CMODE: begin
          shA <= wrData[0];
          shB <= wrData[1];
        end
        ADDR_ACTA: actReg[0] <= wrData[7:0];
        ADDR_ACTB: actReg[1] <= wrData[7:0];
        ADDR_EVCFG: begin
          intEn    <= wrData[0];
          intSrc   <= wrData[2:1];
          intEvery <= wrData[4:3];
          socEn    <= wrData[5];
          socSrc   <= wrData[7:6];
        end
        default: ;
      endcase
    end
  end

  // Two cascaded divide factors folded into one ratio.
  always_comb begin
    fastFac = (fastCode == '0) ? PRE_W'(1) : PRE_W'({fastCode, 1'b0});
    divVal  = fastFac << coarseCode;
    tick    = syncEn && (preCnt >= divVal - PRE_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !syncEn) preCnt <= '0;
    else if (tick)      preCnt <= '0;
    else                preCnt <= preCnt + PRE_W'(1);
  end

  always_comb begin
    ctl.tick    = tick;
    ctl.freeze  = (modeSel == MODE_FREEZE);
    ctl.period  = periodReg;
    ctl.cmpWrA  = wrEn && (wrAddr == ADDR_CMPA);
    ctl.cmpWrB  = wrEn && (wrAddr == ADDR_CMPB);
    ctl.cmpData = wrData;
    ctl.shadowA = shA;
    ctl.shadowB = shB;
    ctl.actCfg  = actReg;
  end

  assign intClr = wrEn && (wrAddr == ADDR_INTCLR) && wrData[0];
  assign intHit = intEn && pickEvt(evt, intSrc) && !intFlag && (intEvery != 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      socPulse <= 1'b0;
    end else begin
      socPulse <= socEn && pickEvt(evt, socSrc);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intFlag  <= 1'b0;
      intPulse <= 1'b0;
      evtCnt   <= '0;
    end else begin
      intPulse <= 1'b0;
      if (intClr) begin
        intFlag <= 1'b0;
        evtCnt  <= '0;
      end else if (!intEn) begin
        evtCnt <= '0;
      end else if (intHit) begin
        if (2'(evtCnt + 2'd1) == intEvery) begin
          intPulse <= 1'b1;
          intFlag  <= 1'b1;
          evtCnt   <= '0;
        end else begin
          evtCnt <= evtCnt + 2'd1;
        end
      end
    end
  end

  // R9
  int_flag_chk: assert property (@(posedge clk) disable iff (rst)
    intPulse |-> intFlag);

  // R9
  int_once_chk: assert property (@(posedge clk) disable iff (rst)
    intPulse |-> !$past(intFlag));

  // R1
  sync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !syncEn |=> (!socPulse && !intPulse));

  // R10
  clr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    intClr |=> !intFlag);

endmodule

// File: rtl/pwm_action_timer.sv
module pwm_action_timer
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              syncEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic              pwmA,
  output logic              pwmB,
  output logic              intPulse,
  output logic              intFlag,
  output logic              socPulse,
  output logic [CNT_W-1:0]  cntVal
);

  dpCtrl_t           ctl;
  cntEvt_t           evt;
  logic [NUM_CH-1:0] pwmOut;

  pwm_regs_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .syncEn   (syncEn),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .evt      (evt),
    .ctl      (ctl),
    .intPulse (intPulse),
    .intFlag  (intFlag),
    .socPulse (socPulse)
  );

  pwm_count_path u_path (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .cnt    (cntVal),
    .evt    (evt),
    .pwmOut (pwmOut)
  );

  assign pwmA = pwmOut[0];
  assign pwmB = pwmOut[1];

endmodule

// File: tb/pwm_action_timer_bench.sv
module pwm_action_timer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        syncEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        pwmA, pwmB, intPulse, intFlag, socPulse;
  logic [15:0] cntVal;

  int checks = 0;
  int failures = 0;
  string curReq = "R11";
  bit finished = 0;

  always #10 clk = ~clk;

  pwm_action_timer u_pwm_action_timer (
    .clk(clk), .rst(rst), .syncEn(syncEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pwmA(pwmA), .pwmB(pwmB), .intPulse(intPulse),
    .intFlag(intFlag), .socPulse(socPulse), .cntVal(cntVal)
  );

  // ---------------- behavioural reference model ----------------
  int mMode, mHs, mCs, mPer, mShA, mShB, mActA, mActB;
  int mIntEn, mIntSrc, mIntN, mSocEn, mSocSrc;
  int mCmpA, mCmpB, mShadA, mShadB;
  int mPre, mCnt, mA, mB, mFlag, mEvt, mIntP, mSoc;

  function automatic int applyAct(int cfg, bit ez, bit ep, bit ea, bit eb, int cur);
    bit present[4];
    int code[4];
    present[0] = ea; code[0] = (cfg >> 4) & 3;
    present[1] = eb; code[1] = (cfg >> 6) & 3;
    present[2] = ep; code[2] = (cfg >> 2) & 3;
    present[3] = ez; code[3] = cfg & 3;
    for (int i = 0; i < 4; i++) begin
      if (present[i] && code[i] != 0) begin
        if (code[i] == 1) return 0;
        if (code[i] == 2) return 1;
        return 1 - cur;
      end
    end
    return cur;
  endfunction

  function automatic bit selEv(int src, bit ez, bit ep, bit ea, bit eb);
    if (src == 0) return ez;
    if (src == 1) return ep;
    if (src == 2) return ea;
    return eb;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mMode = 0; mHs = 0; mCs = 0; mPer = 0; mShA = 0; mShB = 0;
      mActA = 0; mActB = 0; mIntEn = 0; mIntSrc = 0; mIntN = 0;
      mSocEn = 0; mSocSrc = 0; mCmpA = 0; mCmpB = 0; mShadA = 0; mShadB = 0;
      mPre = 0; mCnt = 0; mA = 0; mB = 0; mFlag = 0; mEvt = 0; mIntP = 0; mSoc = 0;
    end else begin
      int div;
      bit tk, run, ez, ep, ea, eb, clr;
      div = (1 << mCs) * ((mHs == 0) ? 1 : 2 * mHs);
      tk = syncEn && (mPre >= div - 1);
      if (!syncEn || tk) mPre = 0; else mPre = mPre + 1;
      run = tk && (mMode != 3);
      ez = run && (mCnt == 0);
      ep = run && (mCnt == mPer);
      ea = run && (mCnt == mCmpA);
      eb = run && (mCnt == mCmpB);
      mA = applyAct(mActA, ez, ep, ea, eb, mA);
      mB = applyAct(mActB, ez, ep, ea, eb, mB);
      if (run) mCnt = (mCnt >= mPer) ? 0 : mCnt + 1;
      mSoc = mSocEn && selEv(mSocSrc, ez, ep, ea, eb);
      mIntP = 0;
      clr = wrEn && wrAddr == 8 && wrData[0];
      if (clr) begin
        mFlag = 0; mEvt = 0;
      end else if (!mIntEn) begin
        mEvt = 0;
      end else if (selEv(mIntSrc, ez, ep, ea, eb) && !mFlag && mIntN != 0) begin
        if (mEvt + 1 == mIntN) begin
          mIntP = 1; mFlag = 1; mEvt = 0;
        end else mEvt = mEvt + 1;
      end
      // compare writes use the shadow mode held before this edge
      if (wrEn && wrAddr == 2) begin
        if (mShA) mShadA = wrData; else mCmpA = wrData;
      end
      if (wrEn && wrAddr == 3) begin
        if (mShB) mShadB = wrData; else mCmpB = wrData;
      end
      if (ez && mShA) mCmpA = mShadA;
      if (ez && mShB) mCmpB = mShadB;
      if (wrEn) begin
        case (wrAddr)
          0: begin mMode = wrData[1:0]; mHs = wrData[4:2]; mCs = wrData[7:5]; end
          1: mPer = wrData;
          4: begin mShA = wrData[0]; mShB = wrData[1]; end
          5: mActA = wrData[7:0];
          6: mActB = wrData[7:0];
          7: begin
            mIntEn = wrData[0]; mIntSrc = wrData[2:1]; mIntN = wrData[4:3];
            mSocEn = wrData[5]; mSocSrc = wrData[7:6];
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", curReq, what, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(cntVal == mCnt[15:0], "cntVal", cntVal, mCnt);
      chk(pwmA == mA[0], "pwmA", pwmA, mA);
      chk(pwmB == mB[0], "pwmB", pwmB, mB);
      chk(socPulse == mSoc[0], "socPulse", socPulse, mSoc);
      chk(intPulse == mIntP[0], "intPulse", intPulse, mIntP);
      chk(intFlag == mFlag[0], "intFlag", intFlag, mFlag);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a[3:0]; wrData = d[15:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int held, pulses;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    curReq = "R11";
    chk(cntVal == 0 && !pwmA && !pwmB && !intFlag && !intPulse && !socPulse,
        "reset outputs", {pwmA, pwmB, intFlag, intPulse, socPulse}, 0);

    // R1 hold while sync low
    curReq = "R1";
    wr(1, 4);
    wr(5, 8'h12);
    wr(6, 8'h0C);
    wr(2, 2);
    idle(10);
    chk(cntVal == 0, "held counter", cntVal, 0);

    // R2 / R5 up count with set-at-zero, clear-at-compare, toggle at period
    curReq = "R2";
    syncEn = 1'b1;
    idle(12);
    curReq = "R5";
    idle(20);

    // R3 divide by 16
    curReq = "R3";
    wr(0, 8'h30);
    idle(250);

    // R7 shadowed compare, new value written mid period
    curReq = "R7";
    wr(4, 1);
    idle(37);
    wr(2, 3);
    idle(200);
    wr(4, 0);
    wr(0, 0);
    wr(3, 1);
    wr(6, 8'hC0);
    idle(30);

    // R6 coincident events: period 0, compare A 0, set at zero vs clear at compare A
    curReq = "R6";
    wr(1, 0);
    wr(2, 0);
    idle(10);
    chk(pwmA == 0, "compare beats zero", pwmA, 0);

    // R4 freeze
    curReq = "R4";
    wr(1, 6);
    idle(5);
    wr(0, 3);
    held = cntVal;
    idle(20);
    chk(cntVal == held, "frozen counter", cntVal, held);
    wr(0, 1);
    idle(20);

    // R8 SOC on compare A
    curReq = "R8";
    wr(2, 2);
    wr(7, 8'hA0);
    pulses = 0;
    for (int i = 0; i < 35; i++) begin
      @(negedge clk);
      if (socPulse) pulses++;
    end
    chk(pulses == 5, "soc pulses in 35 clocks", pulses, 5);
    wr(7, 0);
    idle(20);

    // R9 interrupt every 3rd zero event, flag holds
    curReq = "R9";
    wr(7, 8'h19);
    idle(60);
    chk(intFlag == 1, "flag latched", intFlag, 1);

    // R10 clear, then disable mid count
    curReq = "R10";
    wr(8, 1);
    idle(9);
    wr(7, 0);
    wr(7, 8'h19);
    idle(40);
    wr(8, 1);
    idle(30);

    // R1 stop and restart the gate
    curReq = "R1";
    @(negedge clk);
    syncEn = 1'b0;
    held = cntVal;
    idle(10);
    chk(cntVal == held, "gate low holds", cntVal, held);
    syncEn = 1'b1;
    idle(30);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule